// File: doc/BRIEF.md
# Invalidation Queue Descriptor Processor

This block drains a ring of 16-byte invalidation commands that software places in memory. Software first programs a queue-address register with the ring's 4 KB-aligned base and a size code. It then moves a tail index forward. The block reads each command in turn through a valid/ready read port. It starts at its own head index and stops one short of the tail, wrapping past the last slot back to slot 0. It carries out each command and then steps the head.

Two command kinds are understood. A cache-entry invalidation is accepted and has no side effect. A wait command can optionally store a 32-bit status word through a valid/ready write port, and can optionally raise a one-cycle completion pulse for a separate event block. Any other command kind freezes the ring. The head is left on the offending slot and an error flag is raised. No further reads take place until software clears the flag; processing then resumes from the head.

Both memory ports follow the usual rules for back-pressure. A request stays valid with a stable address (and stable data, for writes) until ready is seen high at a clock edge. The block raises `rd_rsp_ready` only while it is waiting for a response. It does not advance the head before the response, or the write acceptance, has arrived.

Top module: `invq_engine`

## Requirements
- R1: After reset, the queue-address register, the head register and the tail register read zero, `qerr` is low and `busy` is low.
- R2: A queue-address write is dropped when any of bits 11:3 is set or any bit at or above ADDR_W is set. Otherwise it is stored. Bits 2:0 hold the size code and bits ADDR_W-1:12 hold the base.
- R3: A tail write is dropped when any bit outside 18:4 is set, or when its index (bits 18:4) is at or beyond 2^(8+size code). Otherwise it is stored, and the stored value is then readable on `tail_reg`.
- R4: When head equals tail, no read is requested. Otherwise commands are fetched in index order from head up to, but not including, tail. Each fetch goes to base + 16 × index, and the head register (index in bits 18:4) ends equal to the tail.
- R5: A command whose type field (bits 3:0 of the low 64-bit word) is 4 is a no-op. The head advances, and no write or completion pulse is produced.
- R6: For a command of type 5 with bit 5 set, one write of bits 63:32 of the low word is issued. Its address is the high 64-bit word with its two low bits cleared.
- R7: For a command of type 5 with bit 4 set, `wait_done` pulses for exactly one cycle, after any status write has been accepted. Without bit 4 there is no pulse.
- R8: A command of any other type sets `qerr`, leaves the head on that command's index, and issues no write and no pulse.
- R9: While `qerr` is set, no read is requested, even after new tail writes. A `qerr_clr` pulse clears the flag, and fetching restarts from the current head.
- R10: The head advances modulo 2^(8+size code), so it wraps from the last slot to slot 0.
- R11: On both memory ports, a request that is valid but not ready stays valid with unchanged address and data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qa_we | input | 1 | Queue-address register write strobe |
| qa_wdata | input | 64 | Queue-address write value |
| tail_we | input | 1 | Tail register write strobe |
| tail_wdata | input | 32 | Tail write value, index in bits 18:4 |
| qerr_clr | input | 1 | Clears the queue error flag |
| qa_reg | output | 64 | Queue-address register contents |
| head_reg | output | 32 | Head register, index in bits 18:4 |
| tail_reg | output | 32 | Tail register, index in bits 18:4 |
| qerr | output | 1 | Queue error flag |
| busy | output | 1 | A command is being fetched or executed |
| rd_req_valid | output | 1 | Command read request valid |
| rd_req_ready | input | 1 | Command read request accepted |
| rd_req_addr | output | ADDR_W | Command read address |
| rd_rsp_valid | input | 1 | Command read data valid |
| rd_rsp_ready | output | 1 | Block can take read data |
| rd_rsp_data | input | 128 | Command, low word in bits 63:0 |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | ADDR_W | Status write address |
| wr_data | output | 32 | Status write data |
| wait_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take three things for granted about the inputs. The size code does not change while commands are in flight. A read response comes only after an accepted request. Software never rewrites the head, so every change of the head must be a single modular step. The bench keeps to these assumptions. It changes the size code only when the block is idle with head equal to tail. Its memory model answers exactly one response per accepted request. Its ready lines follow a pseudo-random pattern, so holding under back-pressure is exercised on both ports.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam int IDX_W   = 15;  // index occupies register bits 18:4
  localparam int IDX_LSB = 4;   // one step is one 16-byte command
  localparam int CMD_W   = 128;
  localparam logic [3:0] TYPE_CACHE = 4'h4;
  localparam logic [3:0] TYPE_WAIT  = 4'h5;

  typedef struct packed {
    logic        is_cache;
    logic        is_wait;
    logic        irq;
    logic        store;
    logic [31:0] sdata;
    logic [63:0] saddr;
  } cmd_t;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RSP, S_EXEC, S_WR} walk_t;

  function automatic logic [IDX_W-1:0] idx_mask(input logic [2:0] qs, input int order);
    int bits;
    bits = order + int'(qs);
    if (bits > IDX_W) bits = IDX_W;
    return IDX_W'((32'd1 << bits) - 32'd1);
  endfunction
endpackage

// File: rtl/invq_regs.sv
module invq_regs
  import invq_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int ENTRY_ORDER = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qa_we,
  input  logic [63:0]      qa_wdata,
  input  logic             tail_we,
  input  logic [31:0]      tail_wdata,
  output logic [63:0]      qa_q,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W-1:0] mask
);
  localparam logic [63:0] QA_RSVD  = 64'h0000_0000_0000_0FF8;
  localparam logic [63:0] QA_HIGH  = ~((64'd1 << ADDR_W) - 64'd1);
  localparam logic [31:0] TAIL_OK  = 32'h0007_FFF0;

  logic             qa_bad, tail_bad;
  logic [IDX_W-1:0] tail_new;

  assign mask     = idx_mask(qa_q[2:0], ENTRY_ORDER);
  assign qa_bad   = |(qa_wdata & (QA_RSVD | QA_HIGH));
  assign tail_new = tail_wdata[IDX_LSB +: IDX_W];
  assign tail_bad = (|(tail_wdata & ~TAIL_OK)) || (|(tail_new & ~mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qa_q     <= '0;
      tail_idx <= '0;
    end else begin
      if (qa_we && !qa_bad)     qa_q     <= qa_wdata;
      if (tail_we && !tail_bad) tail_idx <= tail_new;
    end
  end
endmodule

// File: rtl/invq_decode.sv
module invq_decode
  import invq_pkg::*;
(
  input  logic [CMD_W-1:0] raw,
  output cmd_t             cmd
);
  logic unused_bits;
  assign unused_bits = ^raw[31:6];

  always_comb begin
    cmd.is_cache = (raw[3:0] == TYPE_CACHE);
    cmd.is_wait  = (raw[3:0] == TYPE_WAIT);
    cmd.irq      = raw[4];
    cmd.store    = raw[5];
    cmd.sdata    = raw[63:32];
    cmd.saddr    = raw[127:64] & ~64'h3;
  end
endmodule

// File: rtl/invq_walker.sv
module invq_walker
  import invq_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  mask,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              err_clr,
  output logic [IDX_W-1:0]  head_idx,
  output logic              qerr,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [CMD_W-1:0]  rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              wait_done
);
  walk_t            st;
  cmd_t             cmd_d, cmd_q;
  logic [IDX_W-1:0] next_idx;
  logic             unused_hi;

  invq_decode u_dec (.raw(rd_rsp_data), .cmd(cmd_d));

  assign next_idx     = (head_idx + 1'b1) & mask;
  assign busy         = (st != S_IDLE);
  assign rd_req_valid = (st == S_REQ);
  assign rd_req_addr  = base + ADDR_W'({head_idx, 4'b0000});
  assign rd_rsp_ready = (st == S_RSP);
  assign wr_valid     = (st == S_WR);
  assign wr_addr      = cmd_q.saddr[ADDR_W-1:0];
  assign wr_data      = cmd_q.sdata;
  assign unused_hi    = ^cmd_q.saddr[63:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      head_idx  <= '0;
      qerr      <= 1'b0;
      wait_done <= 1'b0;
      cmd_q     <= '0;
    end else begin
      wait_done <= 1'b0;
      if (err_clr) qerr <= 1'b0;
      unique case (st)
        S_IDLE: if (!qerr && head_idx != tail_idx) st <= S_REQ;
        S_REQ:  if (rd_req_ready) st <= S_RSP;
        S_RSP:  if (rd_rsp_valid) begin
                  cmd_q <= cmd_d;
                  st    <= S_EXEC;
                end
        S_EXEC: begin
          if (!cmd_q.is_cache && !cmd_q.is_wait) begin
            qerr <= 1'b1;
            st   <= S_IDLE;
          end else if (cmd_q.is_wait && cmd_q.store) begin
            st <= S_WR;
          end else begin
            head_idx  <= next_idx;
            wait_done <= cmd_q.is_wait && cmd_q.irq;
            st        <= S_IDLE;
          end
        end
        S_WR: if (wr_ready) begin
                head_idx  <= next_idx;
                wait_done <= cmd_q.irq;
                st        <= S_IDLE;
              end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/invq_engine.sv
module invq_engine
  import invq_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int ENTRY_ORDER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qa_we,
  input  logic [63:0]       qa_wdata,
  input  logic              tail_we,
  input  logic [31:0]       tail_wdata,
  input  logic              qerr_clr,
  output logic [63:0]       qa_reg,
  output logic [31:0]       head_reg,
  output logic [31:0]       tail_reg,
  output logic              qerr,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [CMD_W-1:0]  rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              wait_done
);
  localparam int PAD_W = 32 - IDX_W - IDX_LSB;

  logic [IDX_W-1:0]  tail_idx, head_idx, mask;
  logic [ADDR_W-1:0] base;

  invq_regs #(.ADDR_W(ADDR_W), .ENTRY_ORDER(ENTRY_ORDER)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .qa_we(qa_we), .qa_wdata(qa_wdata),
    .tail_we(tail_we), .tail_wdata(tail_wdata),
    .qa_q(qa_reg), .tail_idx(tail_idx), .mask(mask)
  );

  assign base = {qa_reg[ADDR_W-1:12], 12'b0};

  invq_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .base(base), .mask(mask), .tail_idx(tail_idx), .err_clr(qerr_clr),
    .head_idx(head_idx), .qerr(qerr), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wait_done(wait_done)
  );

  assign head_reg = {{PAD_W{1'b0}}, head_idx, {IDX_LSB{1'b0}}};
  assign tail_reg = {{PAD_W{1'b0}}, tail_idx, {IDX_LSB{1'b0}}};
endmodule

// File: rtl/invq_engine_chk.sv
module invq_engine_chk
  import invq_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int ENTRY_ORDER = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       qa_reg,
  input logic [31:0]       head_reg,
  input logic              qerr,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wait_done
);
  logic [IDX_W-1:0] hidx, qmask;
  assign hidx  = head_reg[IDX_LSB +: IDX_W];
  assign qmask = idx_mask(qa_reg[2:0], ENTRY_ORDER);

  assert_rdreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_no_fetch_in_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    qerr |-> !rd_req_valid);

  assert_head_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (qerr && $past(qerr)) |-> $stable(head_reg));

  assert_head_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hidx != $past(hidx)) |-> (hidx == (($past(hidx) + 1'b1) & $past(qmask))));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |=> !wait_done);

  assert_addr_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    qa_reg[11:3] == 9'd0);
endmodule

bind invq_engine invq_engine_chk #(.ADDR_W(ADDR_W), .ENTRY_ORDER(ENTRY_ORDER)) u_chk (
  .clk(clk), .rst_n(rst_n), .qa_reg(qa_reg), .head_reg(head_reg), .qerr(qerr),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .wait_done(wait_done)
);

// File: tb/invq_engine_bench.sv
module invq_engine_bench;
  localparam int AW = 48;
  localparam logic [AW-1:0] BASE = 48'h10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic qa_we = 1'b0, tail_we = 1'b0, qerr_clr = 1'b0;
  logic [63:0] qa_wdata = '0;
  logic [31:0] tail_wdata = '0;
  logic [63:0] qa_reg;
  logic [31:0] head_reg, tail_reg;
  logic qerr, busy;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [127:0] rd_rsp_data;
  logic wr_valid, wr_ready, wait_done;
  logic [31:0] wr_data;

  always #4 clk = ~clk;

  invq_engine u_invq_engine (
    .clk(clk), .rst_n(rst_n), .qa_we(qa_we), .qa_wdata(qa_wdata),
    .tail_we(tail_we), .tail_wdata(tail_wdata), .qerr_clr(qerr_clr),
    .qa_reg(qa_reg), .head_reg(head_reg), .tail_reg(tail_reg), .qerr(qerr), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wait_done(wait_done)
  );

  // memory model and event logging
  logic [127:0] mem [0:511];
  logic [15:0]  lfsr;
  int rd_fires = 0, wr_fires = 0, evt_cnt = 0;
  logic [AW-1:0] last_wr_addr, fa [0:15];
  logic [31:0]   last_wr_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1; rd_req_ready <= 1'b0; wr_ready <= 1'b0;
      rd_rsp_valid <= 1'b0; rd_rsp_data <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready <= lfsr[0] | lfsr[3];
      wr_ready     <= lfsr[1] | lfsr[5];
      if (rd_rsp_valid && rd_rsp_ready) rd_rsp_valid <= 1'b0;
      if (rd_req_valid && rd_req_ready) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem[9'((rd_req_addr - BASE) >> 4)];
        if (rd_fires < 16) fa[rd_fires] <= rd_req_addr;
        rd_fires <= rd_fires + 1;
      end
      if (wr_valid && wr_ready) begin
        wr_fires <= wr_fires + 1; last_wr_addr <= wr_addr; last_wr_data <= wr_data;
      end
      if (wait_done) evt_cnt <= evt_cnt + 1;
    end
  end

  int nvec = 0, nbad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] c_cache();
    return {64'h0, 60'h0, 4'h4};
  endfunction
  function automatic logic [127:0] c_wait(input bit st, input bit irq, input logic [31:0] d, input logic [63:0] a);
    return {a[63:2], 2'b11, d, 26'h0, st, irq, 4'h5};
  endfunction

  task automatic w_qa(input logic [63:0] v);
    @(negedge clk); qa_we = 1'b1; qa_wdata = v;
    @(negedge clk); qa_we = 1'b0;
  endtask
  task automatic w_tail(input logic [31:0] v);
    @(negedge clk); tail_we = 1'b1; tail_wdata = v;
    @(negedge clk); tail_we = 1'b0;
  endtask
  task automatic settle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy && (head_reg == tail_reg || qerr)) quiet++; else quiet = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 512; i++) mem[i] = c_cache();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(qa_reg == 0 && head_reg == 0 && tail_reg == 0 && !qerr && !busy, "R1 reset state",
        {qa_reg[31:0], head_reg}, 64'h0);
    // R2
    w_qa(64'h10008);
    chk(qa_reg == 64'h0, "R2 reserved bit drops write", qa_reg, 64'h0);
    w_qa((64'h1 << 50) | 64'h10000);
    chk(qa_reg == 64'h0, "R2 high address bit drops write", qa_reg, 64'h0);
    w_qa(64'h10000);
    chk(qa_reg == 64'h10000, "R2 legal write stored", qa_reg, 64'h10000);
    // R3
    w_tail(32'h18);
    chk(tail_reg == 0, "R3 bit outside index ignored", tail_reg, 0);
    w_tail(32'd256 << 4);
    chk(tail_reg == 0, "R3 index beyond size ignored", tail_reg, 0);
    chk(rd_fires == 0, "R4 no fetch when head equals tail", rd_fires, 0);
    // R4 R5 R11: four no-op commands under back-pressure
    w_tail(32'd4 << 4); settle();
    chk(head_reg == (32'd4 << 4), "R4 head reaches tail", head_reg, 32'd4 << 4);
    chk(rd_fires == 4, "R4 fetch count", rd_fires, 4);
    for (int k = 0; k < 4; k++)
      chk(fa[k] == BASE + 48'(16 * k), "R11 R4 fetch address order", fa[k], BASE + 48'(16 * k));
    chk(wr_fires == 0 && evt_cnt == 0, "R5 no-op has no side effect", {32'(wr_fires), 32'(evt_cnt)}, 0);
    w_tail(32'd4 << 4); repeat (10) @(negedge clk);
    chk(rd_fires == 4, "R4 equal tail rewrite fetches nothing", rd_fires, 4);
    // R6 R7
    mem[4] = c_wait(1'b1, 1'b1, 32'hCAFE_0001, 64'h0234_567B);
    mem[5] = c_wait(1'b0, 1'b0, 32'h1111_2222, 64'h0000_9000);
    mem[6] = c_wait(1'b0, 1'b1, 32'h3333_4444, 64'h0000_A000);
    w_tail(32'd7 << 4); settle();
    chk(wr_fires == 1, "R6 one status write", wr_fires, 1);
    chk(last_wr_addr == 48'h0234_5678, "R6 status address", last_wr_addr, 48'h0234_5678);
    chk(last_wr_data == 32'hCAFE_0001, "R6 status data", last_wr_data, 32'hCAFE_0001);
    chk(evt_cnt == 2, "R7 completion pulses", evt_cnt, 2);
    // R8
    mem[8] = {64'h0, 60'h0, 4'h9};
    w_tail(32'd10 << 4); settle();
    chk(qerr == 1'b1, "R8 error flag set", qerr, 1);
    chk(head_reg == (32'd8 << 4), "R8 head on bad command", head_reg, 32'd8 << 4);
    chk(wr_fires == 1 && evt_cnt == 2, "R8 no side effect", {32'(wr_fires), 32'(evt_cnt)}, {32'd1, 32'd2});
    // R9
    r0 = rd_fires;
    w_tail(32'd12 << 4); repeat (40) @(negedge clk);
    chk(head_reg == (32'd8 << 4), "R9 head frozen in error", head_reg, 32'd8 << 4);
    chk(rd_fires == r0, "R9 no fetch in error", rd_fires, r0);
    mem[8] = c_cache();
    @(negedge clk); qerr_clr = 1'b1; @(negedge clk); qerr_clr = 1'b0;
    settle();
    chk(!qerr && head_reg == (32'd12 << 4), "R9 resume after clear", head_reg, 32'd12 << 4);
    chk(rd_fires == r0 + 4, "R9 refetch from head", rd_fires, r0 + 4);
    // R10 wraparound at 256 entries
    w_tail(32'd250 << 4); settle();
    r0 = rd_fires;
    w_tail(32'd3 << 4); settle();
    chk(head_reg == (32'd3 << 4), "R10 head wraps", head_reg, 32'd3 << 4);
    chk(rd_fires == r0 + 9, "R10 wrap fetch count", rd_fires, r0 + 9);
    // R3 R10 with size code 1 (512 entries)
    w_qa(64'h10001);
    w_tail(32'd300 << 4);
    chk(tail_reg == (32'd300 << 4), "R3 larger ring accepts index", tail_reg, 32'd300 << 4);
    settle();
    chk(head_reg == (32'd300 << 4), "R10 head past 256 in larger ring", head_reg, 32'd300 << 4);
    w_tail(32'd512 << 4);
    chk(tail_reg == (32'd300 << 4), "R3 index 512 rejected", tail_reg, 32'd300 << 4);
    w_tail(32'd0); settle();
    chk(head_reg == 0, "R10 larger ring wraps to zero", head_reg, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule